// File: doc/BRIEF.md
# Serial Eight-Channel ADC Conversation Sequencer

This block drives an eight-channel, 12-bit converter over a four-wire serial link. It is the master side of the link. A one-cycle `go` request from the core starts one conversation. During a conversation, chip select is held low for sixteen serial clock periods. In that time the block sends a 12-bit command word and then trailing zeros. At the same time it collects a 3-bit channel tag and a 12-bit sample from the converter. The sample belongs to the channel that the previous conversation selected. At the end of the conversation, the channel tag and sample are presented to the core together with a one-cycle `done` strobe.

The command word always has the shape W,0,0,A2,A1,A0,1,1,0,0,0,0. Only its leading bit W differs between a plain read (W=0, the converter keeps its settings) and a channel select (W=1, the converter loads the new address). After reset, the block issues two start-up conversations on its own. In these it drives ones on every data-out bit, and it throws away whatever comes back. A request that arrives during start-up is remembered, along with its write flag and address, and it runs as soon as start-up ends.

The result side is a plain strobe, not a valid/ready channel. The converter sets the pace, and a result cannot be held back. The core must take `chan` and `data` in the cycle `done` is high, or at any time before the next `done`, because the outputs hold their value until then. Each serial clock period lasts `2*HALF_PER` system clocks.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `cs_n`=1, `sclk`=1, `mosi`=0, `done`=0, `chan`=0 and `data`=0.
- R2: After reset is released, exactly two start-up conversations run without any request. Each sends sixteen 1 bits, and neither one pulses `done`.
- R3: A `go` seen before start-up ends is kept pending, together with the `wr` and `addr` values of that cycle. It launches one conversation with those values once start-up is over.
- R4: A `go` while idle starts a conversation. `cs_n` is low for 16 serial periods (32 system clocks at the default). This is followed by one further serial period with `cs_n` high, and only after that can a new request be accepted.
- R5: A `go` during a conversation, including its final high-`cs_n` period, is ignored. It starts no conversation and its `wr` and `addr` are never sent.
- R6: The 16 bits sent, MSB first, are {W,0,0,A2,A1,A0,1,1,0,0,0,0,0,0,0,0}, where W is `wr` and A is `addr`. `mosi` changes only while `sclk` is low and is stable at each `sclk` rising edge.
- R7: While `cs_n` is high, `mosi` is 0 and `sclk` is 1.
- R8: `miso` is sampled at each of the 16 `sclk` rising edges. The first sample is dropped. The next three form `chan`, MSB first, and the last twelve form `data`, MSB first.
- R9: `done` is high for exactly one cycle. It rises in the cycle in which `cs_n` returns high, with `chan` and `data` already updated. Both outputs then hold until the next `done`.
- R10: Data received in the start-up conversations is discarded, and `chan` and `data` stay 0 through them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Conversation request, one-cycle pulse |
| wr | input | 1 | Write flag placed in the leading command bit |
| addr | input | 3 | Channel address placed in the command word |
| chan | output | 3 | Channel tag of the last received sample |
| data | output | 12 | Last received sample |
| done | output | 1 | One-cycle strobe marking a new result |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data toward the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
The bench models the converter's control register. Because the start-up words are all ones, they secretly select channel 7. If start-up words were malformed, or if the block skipped them, the first real result would carry the wrong channel tag. A request issued right after reset checks the pending path: a design that dropped it would never raise `done`, and one that sampled `wr` and `addr` late would send the wrong command. A burst of extra requests during a run, with a different address, checks that they are ignored: a faulty design would produce an extra chip-select pulse or a changed channel two conversations later. Samples with a single bit set at either end (0x800, 0x001), together with the exact chip-select low time, expose bit-order and off-by-one errors in the shift registers and the counters.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_LEN = 16;
  localparam int CH_W      = 3;
  localparam int SMP_W     = 12;
  localparam int RX_LEN    = CH_W + SMP_W;
  localparam int N_BOOT    = 2;
  localparam int BOOT_W    = $clog2(N_BOOT + 1);

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic [SMP_W-1:0] smp;
  } result_t;

  // Command word: write flag, two zeros, channel, power bits set, then zeros.
  function automatic logic [FRAME_LEN-1:0] cmd_word(input logic w,
                                                    input logic [CH_W-1:0] a);
    logic [11:0] c;
    c = {w, 2'b00, a, 2'b11, 4'b0000};
    return {c, {(FRAME_LEN-12){1'b0}}};
  endfunction
endpackage

// File: rtl/adc_bit_timer.sv
module adc_bit_timer #(
  parameter int HALF_PER = 1,
  parameter int FRAME    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic in_frame,
  output logic sclk,
  output logic sample_stb,
  output logic shift_stb,
  output logic frame_end,
  output logic run_end
);
  localparam int PER = 2 * HALF_PER;
  localparam int PW  = (PER > 2) ? $clog2(PER) : 1;
  localparam int BW  = $clog2(FRAME + 1);
  localparam logic [PW-1:0] PH_MID  = PW'(HALF_PER - 1);
  localparam logic [PW-1:0] PH_END  = PW'(PER - 1);
  localparam logic [BW-1:0] BIT_LST = BW'(FRAME - 1);
  localparam logic [BW-1:0] BIT_TL  = BW'(FRAME);

  logic          active_q;
  logic [BW-1:0] bit_q;
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      ph_q     <= '0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        bit_q    <= '0;
        ph_q     <= '0;
      end
    end else if (ph_q == PH_END) begin
      ph_q <= '0;
      if (bit_q == BIT_TL) active_q <= 1'b0;
      else                 bit_q    <= bit_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign busy       = active_q;
  assign in_frame   = active_q && (bit_q != BIT_TL);
  assign sclk       = !in_frame || (ph_q > PH_MID);
  assign sample_stb = in_frame && (ph_q == PH_MID);
  assign shift_stb  = in_frame && (ph_q == PH_END);
  assign frame_end  = shift_stb && (bit_q == BIT_LST);
  assign run_end    = active_q && (bit_q == BIT_TL) && (ph_q == PH_END);
endmodule

// File: rtl/adc_tx_shift.sv
module adc_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         enable,
  output logic         sout
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign sout = enable & sr_q[W-1];
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int HALF_PER = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             wr,
  input  logic [CH_W-1:0]  addr,
  output logic [CH_W-1:0]  chan,
  output logic [SMP_W-1:0] data,
  output logic             done,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  logic busy, in_frame, sample_stb, shift_stb, frame_end, run_end, start;
  logic [BOOT_W-1:0] boot_left_q;
  logic              booting, cur_boot_q;
  logic              pend_q, pend_wr_q;
  logic [CH_W-1:0]   pend_addr_q;
  logic              launch_wr;
  logic [CH_W-1:0]   launch_addr;
  logic [FRAME_LEN-1:0] tx_word;
  logic [RX_LEN-1:0] rx_bits;
  result_t           res_q;

  assign booting     = (boot_left_q != '0);
  assign start       = !busy && (booting || pend_q || go);
  assign launch_wr   = pend_q ? pend_wr_q : wr;
  assign launch_addr = pend_q ? pend_addr_q : addr;
  assign tx_word     = booting ? '1 : cmd_word(launch_wr, launch_addr);

  adc_bit_timer #(.HALF_PER(HALF_PER), .FRAME(FRAME_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .in_frame(in_frame), .sclk(sclk), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .frame_end(frame_end), .run_end(run_end)
  );

  adc_tx_shift #(.W(FRAME_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(tx_word),
    .shift(shift_stb), .enable(in_frame), .sout(mosi)
  );

  adc_rx_shift #(.W(RX_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .shift(sample_stb), .sin(miso), .q(rx_bits)
  );

  // Start-up bookkeeping and the request held over start-up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_left_q <= BOOT_W'(N_BOOT);
      cur_boot_q  <= 1'b0;
      pend_q      <= 1'b0;
      pend_wr_q   <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      if (start) cur_boot_q <= booting;
      if (run_end && cur_boot_q) boot_left_q <= boot_left_q - 1'b1;
      if (booting && go) begin
        pend_q      <= 1'b1;
        pend_wr_q   <= wr;
        pend_addr_q <= addr;
      end else if (start && !booting) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= frame_end && !cur_boot_q;
      if (frame_end && !cur_boot_q) res_q <= result_t'(rx_bits);
    end
  end

  assign chan = res_q.ch;
  assign data = res_q.smp;
  assign cs_n = !in_frame;
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk
  import adc_seq_pkg::*;
#(
  parameter int HALF_PER = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             done,
  input logic [CH_W-1:0]  chan,
  input logic [SMP_W-1:0] data
);
  localparam int LOW_LEN = FRAME_LEN * 2 * HALF_PER;
  localparam int CW = $clog2(LOW_LEN + 2);

  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= '0;
    else if (!cs_n) low_cnt <= low_cnt + 1'b1;
    else            low_cnt <= '0;
  end

  a_r7_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);
  a_r7_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  a_r6_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  a_r4_cs_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && low_cnt != '0) |-> (low_cnt == CW'(LOW_LEN)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(chan) && $stable(data)));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.HALF_PER(HALF_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .done(done), .chan(chan), .data(data)
);

// File: tb/tb_adc_conv_ctrl.sv
module tb_adc_conv_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0, chan;
  logic [11:0] data;
  logic done, cs_n, sclk, mosi, miso;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  adc_conv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .go(go), .wr(wr), .addr(addr), .chan(chan),
    .data(data), .done(done), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // Converter model: control register, shift out {0, ch, sample}.
  logic [2:0]  adc_ch = 3'd0;
  logic [11:0] adc_val = 12'd0;
  logic [15:0] adc_frame = '0, cap = '0, last_word = '0;
  logic [15:0] boot_words [2];
  int bit_i = 0, words_seen = 0, cs_falls = 0, done_cnt = 0;

  always @(negedge cs_n) begin
    bit_i = 0;
    adc_frame = {1'b0, adc_ch, adc_val};
    cs_falls++;
  end
  always @(posedge sclk) if (cs_n == 1'b0) begin
    cap = {cap[14:0], mosi};
    bit_i = bit_i + 1;
  end
  always @(posedge cs_n) if (bit_i == 16) begin
    last_word = cap;
    if (words_seen < 2) boot_words[words_seen] = cap;
    if (cap[15]) adc_ch = cap[12:10];
    words_seen++;
    bit_i = 0;
  end
  assign miso = (cs_n == 1'b0 && bit_i < 16) ? adc_frame[15 - bit_i] : 1'b0;

  always @(negedge clk) if (done === 1'b1) done_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic w, input logic [2:0] a);
    return {w, 2'b00, a, 2'b11, 8'h00};
  endfunction

  task automatic wait_done(output int lows);
    int n = 0;
    lows = 0;
    while (done !== 1'b1 && n < 400) begin
      @(negedge clk);
      if (cs_n == 1'b0) lows++;
      n++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 1); chk("R1 mosi", mosi, 0);
    chk("R1 done", done, 0); chk("R1 chan", chan, 0); chk("R1 data", data, 0);
  endtask

  // Request during start-up, then the start-up words and the pending run.
  task automatic t_boot_pending;
    int lows;
    adc_val = 12'hA5C;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) begin go = 1'b1; wr = 1'b1; addr = 3'd3; end
    @(negedge clk) begin go = 1'b0; wr = 1'b0; addr = 3'd0; end
    while (words_seen < 2) @(negedge clk);
    chk("R2 boot word 0", boot_words[0], 16'hFFFF);
    chk("R2 boot word 1", boot_words[1], 16'hFFFF);
    chk("R2 no done in boot", done_cnt, 0);
    chk("R10 chan after boot", chan, 0);
    chk("R10 data after boot", data, 0);
    wait_done(lows);
    chk("R3 pending run done", done, 1);
    chk("R3 pending word", last_word, exp_word(1'b1, 3'd3));
    chk("R8 chan from boot select", chan, 7);
    chk("R8 data", data, 12'hA5C);
    chk("R2 boot conversations", cs_falls, 3);
  endtask

  task automatic t_conv(input logic w, input logic [2:0] a, input logic [11:0] v,
                        input logic [2:0] ech, input string tag);
    int lows;
    repeat (4) @(negedge clk);
    adc_val = v;
    @(negedge clk) begin go = 1'b1; wr = w; addr = a; end
    @(negedge clk) begin go = 1'b0; wr = 1'b0; addr = 3'd0; end
    lows = (cs_n == 1'b0) ? 1 : 0;
    begin
      int more;
      wait_done(more);
      lows += more;
    end
    chk({"R4 cs low cycles ", tag}, lows, 32);
    chk({"R9 done seen ", tag}, done, 1);
    chk({"R9 cs high with done ", tag}, cs_n, 1);
    chk({"R6 word ", tag}, last_word, exp_word(w, a));
    chk({"R8 chan ", tag}, chan, ech);
    chk({"R8 data ", tag}, data, v);
    @(negedge clk);
    chk({"R9 done one cycle ", tag}, done, 0);
  endtask

  task automatic t_ignore_go;
    int f0, d0;
    repeat (4) @(negedge clk);
    f0 = cs_falls; d0 = done_cnt;
    adc_val = 12'hFFF;
    @(negedge clk) begin go = 1'b1; wr = 1'b1; addr = 3'd5; end
    @(negedge clk) begin go = 1'b0; wr = 1'b0; end
    repeat (10) @(negedge clk);
    @(negedge clk) begin go = 1'b1; wr = 1'b1; addr = 3'd2; end
    @(negedge clk) go = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    chk("R8 chan before ignore", chan, 6);
    @(negedge clk) begin go = 1'b1; wr = 1'b1; addr = 3'd2; end
    @(negedge clk) begin go = 1'b0; wr = 1'b0; addr = 3'd0; end
    repeat (10) @(negedge clk);
    chk("R5 one conversation", cs_falls - f0, 1);
    chk("R5 one done", done_cnt - d0, 1);
    chk("R5 word kept", last_word, exp_word(1'b1, 3'd5));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cs_n !== 1'b1 || mosi !== 1'b0 || sclk !== 1'b1)
        chk("R7 idle pins", {cs_n, sclk, mosi}, 3'b110);
    end
    chk("R9 chan held", chan, 6);
    chk("R9 data held", data, 12'hFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_boot_pending;
    t_conv(1'b0, 3'd5, 12'h123, 3'd3, "read");
    t_conv(1'b1, 3'd6, 12'h800, 3'd3, "select6");
    t_conv(1'b0, 3'd0, 12'h001, 3'd6, "read6");
    t_ignore_go;
    t_conv(1'b0, 3'd1, 12'h5A3, 3'd5, "after-ignore");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule